// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the set of live lanes for one warp of 32 lanes that share a single program counter. Lanes that must not run an instruction are switched off in a mask rather than given their own counter. When a branch event arrives, the per-lane condition is combined with the current mask. If every live lane agrees, the warp simply jumps to the chosen side and the other side costs nothing. If at least one live lane goes each way, the taken side runs first under its own mask. The other side's mask, its start address and the join address are pushed on a small stack.

The surrounding front end reports each step of the warp as an advance carrying the next sequential address. When that address equals the join address on top of the stack, the block switches to the pending other side under the complementary mask. On the second arrival at the join, it pops the entry and restores the mask that was live before the branch. When the stack becomes empty this is the mask given at launch. Branch targets and join addresses are always supplied by the caller. Outputs are registered and change on the clock edge after the event.

Top module: `simt_mask_stack`

## Requirements
- R1: While reset is low and on the first sample after it, active_mask, pc and depth are 0, and path_skip and overflow are 0.
- R2: A launch loads active_mask from launch_mask and pc from launch_pc, and empties the stack (depth 0).
- R3: A branch where every live lane has its condition bit set sets pc to br_target, leaves active_mask and depth unchanged, and raises path_skip for one cycle.
- R4: A branch where no live lane has its condition bit set sets pc to br_else_pc, leaves active_mask and depth unchanged, and raises path_skip for one cycle.
- R5: A branch with at least one live lane on each side, even a single lane, sets active_mask to cond AND mask and pc to br_target, and increments depth. path_skip stays 0.
- R6: An advance whose address equals the top join address, while the top entry is still on its taken side, sets active_mask to (NOT cond) AND the pre-branch mask and pc to the saved else address. Depth is unchanged.
- R7: An advance whose address equals the top join address on the other side pops the entry and sets pc to the join address. active_mask becomes the pre-branch mask, or the launch mask when depth falls to 0.
- R8: Any other advance sets pc to adv_pc and leaves active_mask and depth unchanged.
- R9: active_mask never has a lane set that was clear in the last launch mask.
- R10: A divergent branch at depth DEPTH (8) changes nothing except raising overflow for one cycle.
- R11: When several events coincide, launch wins over branch, and branch wins over advance.
- R12: path_skip and overflow are 0 after any cycle that did not cause them, and never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Start the warp |
| launch_mask | input | LANES | Lanes present at launch |
| launch_pc | input | PCW | Start address |
| br_valid | input | 1 | Branch event |
| br_cond | input | LANES | Per-lane branch condition |
| br_target | input | PCW | Taken-side address |
| br_else_pc | input | PCW | Not-taken-side address |
| br_join_pc | input | PCW | Reconvergence address |
| adv_valid | input | 1 | Sequential step event |
| adv_pc | input | PCW | Next sequential address |
| active_mask | output | LANES | Live lanes |
| pc | output | PCW | Warp program counter |
| path_skip | output | 1 | A branch side was skipped |
| depth | output | $clog2(DEPTH+1) | Stack occupancy |
| overflow | output | 1 | Divergent branch with full stack |

## Verification
Branches are driven with condition vectors that are all ones, all zeros, a single lane, and random. These separate the uniform-taken skip, the uniform-not-taken skip and divergence, and show that one lane is enough to diverge. Launch masks that are partial check that absent lanes never come back on either side. A directed chain peels off one lane per level to reach full depth, then one more divergent branch checks overflow. Random advances that hit or miss the top join address tell switching sides, popping and plain stepping apart.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_valid,
  input  logic [LANES-1:0]           launch_mask,
  input  logic [PCW-1:0]             launch_pc,
  input  logic                       br_valid,
  input  logic [LANES-1:0]           br_cond,
  input  logic [PCW-1:0]             br_target,
  input  logic [PCW-1:0]             br_else_pc,
  input  logic [PCW-1:0]             br_join_pc,
  input  logic                       adv_valid,
  input  logic [PCW-1:0]             adv_pc,
  output logic [LANES-1:0]           active_mask,
  output logic [PCW-1:0]             pc,
  output logic                       path_skip,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       overflow
);
  localparam int DW = $clog2(DEPTH+1);

  logic [LANES-1:0] base_mask;
  logic [LANES-1:0] stk_parent [DEPTH];
  logic [LANES-1:0] stk_else   [DEPTH];
  logic [PCW-1:0]   stk_epc    [DEPTH];
  logic [PCW-1:0]   stk_jpc    [DEPTH];
  logic             stk_ph     [DEPTH];

  logic [DW-1:0]    top;
  logic [LANES-1:0] taken, other, restore;
  logic             diverge, full, at_join, do_push, do_flip;

  assign top     = depth - 1'b1;
  assign taken   = br_cond & active_mask;
  assign other   = ~br_cond & active_mask;
  assign diverge = (|taken) && (|other);
  assign full    = depth == DW'(DEPTH);
  assign at_join = (depth != '0) && (adv_pc == stk_jpc[top]);
  assign restore = (depth == DW'(1)) ? base_mask : stk_parent[top];
  assign do_push = !launch_valid && br_valid && diverge && !full;
  assign do_flip = !launch_valid && !br_valid && adv_valid && at_join && !stk_ph[top];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '0;
      base_mask   <= '0;
      pc          <= '0;
      depth       <= '0;
      path_skip   <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      path_skip <= 1'b0;
      overflow  <= 1'b0;
      if (launch_valid) begin
        active_mask <= launch_mask;
        base_mask   <= launch_mask;
        pc          <= launch_pc;
        depth       <= '0;
      end else if (br_valid) begin
        if (diverge) begin
          if (full) begin
            overflow <= 1'b1;
          end else begin
            active_mask <= taken;
            pc          <= br_target;
            depth       <= depth + 1'b1;
          end
        end else if (|taken) begin
          pc        <= br_target;
          path_skip <= 1'b1;
        end else begin
          pc        <= br_else_pc;
          path_skip <= 1'b1;
        end
      end else if (adv_valid) begin
        if (at_join) begin
          if (!stk_ph[top]) begin
            active_mask <= stk_else[top];
            pc          <= stk_epc[top];
          end else begin
            active_mask <= restore;
            pc          <= stk_jpc[top];
            depth       <= depth - 1'b1;
          end
        end else begin
          pc <= adv_pc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      stk_parent[depth] <= active_mask;
      stk_else[depth]   <= other;
      stk_epc[depth]    <= br_else_pc;
      stk_jpc[depth]    <= br_join_pc;
      stk_ph[depth]     <= 1'b0;
    end
    if (do_flip) stk_ph[top] <= 1'b1;
  end

  // R9
  lane_contain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask & ~base_mask) == '0);

  // R5
  nest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(depth) == DW'(DEPTH)) && $stable(depth) && $stable(active_mask));

  // R3
  skip_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_skip |-> $stable(depth) && $stable(active_mask));

  // R5
  mask_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(br_valid && !launch_valid) |-> (active_mask & ~$past(active_mask)) == '0);

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(path_skip && overflow));
endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        launch_valid = 0, br_valid = 0, adv_valid = 0;
  logic [31:0] launch_mask = 0, launch_pc = 0, br_cond = 0, br_target = 0;
  logic [31:0] br_else_pc = 0, br_join_pc = 0, adv_pc = 0;
  logic [31:0] active_mask, pc;
  logic        path_skip, overflow;
  logic [3:0]  depth;

  simt_mask_stack u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_mask = 0, m_base = 0, m_pc = 0;
  bit m_skip = 0, m_ovf = 0;
  logic [31:0] q_parent[$], q_else[$], q_epc[$], q_jpc[$];
  bit q_ph[$];
  int jcnt = 0;
  string tag;

  task automatic compare(string t);
    checks++;
    if (active_mask !== m_mask || pc !== m_pc || path_skip !== m_skip ||
        overflow !== m_ovf || depth !== 4'(q_jpc.size())) begin
      fails++;
      $display("FAIL %s: actual mask=%h pc=%h skip=%b ovf=%b depth=%0d expected mask=%h pc=%h skip=%b ovf=%b depth=%0d",
               t, active_mask, pc, path_skip, overflow, depth, m_mask, m_pc, m_skip, m_ovf, q_jpc.size());
    end
    checks++;
    if ((active_mask & ~m_base) !== 0) begin
      fails++;
      $display("FAIL R9: actual mask=%h expected within %h", active_mask, m_base);
    end
  endtask

  task automatic cyc(bit l, logic [31:0] lm, logic [31:0] lpc, bit b, logic [31:0] c,
                     logic [31:0] tp, logic [31:0] ep, logic [31:0] jp, bit a, logic [31:0] np);
    logic [31:0] t, e;
    int n;
    launch_valid = l; launch_mask = lm; launch_pc = lpc;
    br_valid = b; br_cond = c; br_target = tp; br_else_pc = ep; br_join_pc = jp;
    adv_valid = a; adv_pc = np;
    m_skip = 0; m_ovf = 0; tag = "R12";
    n = q_jpc.size();
    if (l) begin
      tag = "R2"; m_mask = lm; m_base = lm; m_pc = lpc;
      q_parent.delete(); q_else.delete(); q_epc.delete(); q_jpc.delete(); q_ph.delete();
    end else if (b) begin
      t = c & m_mask; e = ~c & m_mask;
      if (t != 0 && e != 0) begin
        if (n == 8) begin m_ovf = 1; tag = "R10"; end
        else begin
          q_parent.push_back(m_mask); q_else.push_back(e); q_epc.push_back(ep);
          q_jpc.push_back(jp); q_ph.push_back(0);
          m_mask = t; m_pc = tp; tag = "R5";
        end
      end else if (t != 0) begin m_pc = tp; m_skip = 1; tag = "R3"; end
      else begin m_pc = ep; m_skip = 1; tag = "R4"; end
    end else if (a) begin
      if (n > 0 && np == q_jpc[n-1]) begin
        if (!q_ph[n-1]) begin
          m_mask = q_else[n-1]; m_pc = q_epc[n-1]; q_ph[n-1] = 1; tag = "R6";
        end else begin
          m_mask = (n == 1) ? m_base : q_parent[n-1]; m_pc = q_jpc[n-1];
          void'(q_parent.pop_back()); void'(q_else.pop_back()); void'(q_epc.pop_back());
          void'(q_jpc.pop_back()); void'(q_ph.pop_back());
          tag = "R7";
        end
      end else begin m_pc = np; tag = "R8"; end
    end
    if (int'(l) + int'(b) + int'(a) > 1) tag = {"R11/", tag};
    @(posedge clk); #2;
    compare(tag);
    @(negedge clk);
  endtask

  function automatic logic [31:0] jpc_new();
    jcnt++;
    return 32'h8000_0000 | 32'(jcnt);
  endfunction

  function automatic logic [31:0] top_jpc();
    return q_jpc.size() > 0 ? q_jpc[q_jpc.size()-1] : 32'h0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(posedge clk); #2;
    compare("R1");
    @(negedge clk);
    cyc(1, 32'h00FF_FF0F, 32'h100, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF, 32'h200, 32'h300, jpc_new(), 0, 0);
    cyc(0, 0, 0, 1, 32'h0, 32'h210, 32'h310, jpc_new(), 0, 0);
    cyc(0, 0, 0, 1, 32'hFF00_00F0, 32'h220, 32'h320, jpc_new(), 0, 0);
    cyc(0, 0, 0, 1, 32'h0000_0008, 32'h230, 32'h330, jpc_new(), 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h234);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, top_jpc());
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h334);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, top_jpc());
    for (int k = 0; k < 9; k++)
      cyc(0, 0, 0, 1, m_mask & (m_mask - 1), 32'h400 + 32'(k), 32'h500 + 32'(k), jpc_new(), 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++)
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, top_jpc());
    cyc(0, 0, 0, 1, 32'h0000_0003, 32'h600, 32'h610, jpc_new(), 1, 32'h620);
    cyc(1, 32'h0000_FFFF, 32'h700, 1, 32'h0000_00FF, 32'h710, 32'h720, jpc_new(), 1, 32'h730);
    cyc(0, 0, 0, 1, 32'h0000_0F00, 32'h740, 32'h750, jpc_new(), 1, 32'h760);
    for (int i = 0; i < 5000; i++) begin
      int r, k;
      logic [31:0] c;
      r = int'($urandom_range(0, 99));
      k = int'($urandom_range(0, 3));
      c = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0 :
          (k == 2) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      if (r < 3)
        cyc(1, (r == 0) ? 32'hFFFF_FFFF : $urandom, $urandom & 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
      else if (r < 45)
        cyc(0, 0, 0, 1, c, $urandom & 32'h7FFF_FFFF, $urandom & 32'h7FFF_FFFF, jpc_new(), r < 8, $urandom & 32'h7FFF_FFFF);
      else if (r < 95)
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1,
            (q_jpc.size() > 0 && r < 75) ? top_jpc() : ($urandom & 32'h7FFF_FFFF));
      else
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule